// File: doc/BRIEF.md
# Time-Signal Pulse Classifier and Frame Assembler

This block sits behind a pulse-width measurement stage on a long-wave time-signal receiver. Each measured pulse arrives as a tick count (one tick = 25 ms) qualified by a one-cycle strobe. The block sorts every pulse into one of five classes: a short logic-zero pulse (about 100 ms), a long logic-one pulse (about 200 ms), the long gap that marks the start of a minute, a runt that is too short to trust, or a length that fits no class.

Data pulses are written into a 64-bit store at the position given by a running bit counter. Runts and minute marks send the counter back to zero. When the fifty-ninth bit of a minute is written, the whole store, including that bit, is copied to a frame output register, the counter restarts and a ready flag is raised. The flag stays up until the host acknowledges it.

Top module: `dcf_frame_assembler`

## Requirements
- R1: A strobed length below 3 ticks (0, 1 or 2) is a runt. It clears the bit counter, so the next data pulse is bit 0 of a new frame.
- R2: A strobed length of 3, 4 or 5 ticks writes a 0 at the current bit index and advances the counter by one.
- R3: A strobed length of 7, 8 or 9 ticks writes a 1 at the current bit index and advances the counter by one.
- R4: A strobed length from 40 to 83 ticks inclusive is the minute mark. It clears the bit counter.
- R5: Bit n of a minute is stored in byte n/8 at bit n%8. Byte k is `frame_data[8k+7:8k]`, so bit n appears at `frame_data[n]`.
- R6: When bit 58 (the 59th bit) is written, `frame_data` takes the store including that bit and `frame_ready` rises on the same clock edge. The counter returns to 0.
- R7: Lengths of 6, 10 to 39, and 84 or more ticks, and cycles without a strobe, leave the counter and the store unchanged.
- R8: `frame_ready` stays high until a cycle in which `host_ack` is high. It is low after that edge.
- R9: If a frame completes in the same cycle as `host_ack`, `frame_ready` stays high and `frame_data` shows the new frame.
- R10: Synchronous active-high reset clears the counter, the store, `frame_data` and `frame_ready`. Store bits 59 to 63 are never written and read as 0.
- R11: `frame_data` holds its value between frame completions, whatever pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_valid | input | 1 | One-cycle strobe qualifying pulse_ticks |
| pulse_ticks | input | TICK_W (8) | Measured pulse length in 25 ms ticks |
| host_ack | input | 1 | Host acknowledge, clears frame_ready |
| frame_ready | output | 1 | A completed frame is waiting |
| frame_data | output | 8*BUF_BYTES (64) | Last completed frame, bit n = minute bit n |

## Verification
The hardest case to reach is a frame that completes on the same edge as an acknowledge. To get there, the bench first completes a frame and leaves it unacknowledged. It then clocks in 58 more bits and drives the 59th bit's strobe together with `host_ack`. The counter is not visible at the ports, so the bench proves that runts, minute marks and ignored lengths acted on it by timing: it checks that `frame_ready` rises exactly on the data pulse that the requirements predict, and not one pulse earlier.

// File: rtl/dcf_frame_pkg.sv
package dcf_frame_pkg;

  typedef enum logic [2:0] {
    PC_RUNT,
    PC_ZERO,
    PC_ONE,
    PC_MINUTE,
    PC_OTHER
  } pulse_class_e;

endpackage

// File: rtl/dcf_pulse_classify.sv
module dcf_pulse_classify
  import dcf_frame_pkg::*;
#(
  parameter int TICK_W   = 8,
  parameter int ZERO_MIN = 3,
  parameter int ZERO_MAX = 5,
  parameter int ONE_MIN  = 7,
  parameter int ONE_MAX  = 9,
  parameter int MARK_LO  = 39,  // exclusive
  parameter int MARK_HI  = 84   // exclusive
) (
  input  logic [TICK_W-1:0] ticks_i,
  output pulse_class_e      class_o
);

  localparam logic [TICK_W-1:0] ZMIN = TICK_W'(ZERO_MIN);
  localparam logic [TICK_W-1:0] ZMAX = TICK_W'(ZERO_MAX);
  localparam logic [TICK_W-1:0] OMIN = TICK_W'(ONE_MIN);
  localparam logic [TICK_W-1:0] OMAX = TICK_W'(ONE_MAX);
  localparam logic [TICK_W-1:0] MLO  = TICK_W'(MARK_LO);
  localparam logic [TICK_W-1:0] MHI  = TICK_W'(MARK_HI);

  always_comb begin
    if (ticks_i < ZMIN)
      class_o = PC_RUNT;
    else if (ticks_i <= ZMAX)
      class_o = PC_ZERO;
    else if (ticks_i >= OMIN && ticks_i <= OMAX)
      class_o = PC_ONE;
    else if (ticks_i > MLO && ticks_i < MHI)
      class_o = PC_MINUTE;
    else
      class_o = PC_OTHER;
  end

endmodule

// File: rtl/dcf_bit_store.sv
module dcf_bit_store
  import dcf_frame_pkg::*;
#(
  parameter int BUF_BYTES  = 8,
  parameter int FRAME_BITS = 59
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     strobe_i,
  input  pulse_class_e             class_i,
  output logic [$clog2(BUF_BYTES*8)-1:0] cnt_o,
  output logic                     done_o,
  output logic [BUF_BYTES*8-1:0]   next_o
);

  localparam int BUF_BITS = BUF_BYTES * 8;
  localparam int CNT_W    = $clog2(BUF_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       byte_q [BUF_BYTES];
  logic             is_data;
  logic             bit_val;

  assign is_data = strobe_i && (class_i == PC_ZERO || class_i == PC_ONE);
  assign bit_val = (class_i == PC_ONE);
  assign done_o  = is_data && (cnt_q == LAST_IDX);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (strobe_i) begin
      if (class_i == PC_RUNT || class_i == PC_MINUTE)
        cnt_q <= '0;
      else if (is_data)
        cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
    logic       sel;
    logic [7:0] byte_next;
    assign sel = is_data && (cnt_q[CNT_W-1:3] == (CNT_W-3)'(b));

    always_comb begin
      byte_next = byte_q[b];
      if (sel)
        byte_next[cnt_q[2:0]] = bit_val;
    end

    always_ff @(posedge clk) begin
      if (rst)
        byte_q[b] <= '0;
      else
        byte_q[b] <= byte_next;
    end

    assign next_o[8*b +: 8] = byte_next;
  end

endmodule

// File: rtl/dcf_frame_hold.sv
module dcf_frame_hold #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] store_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] frame_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_o <= 1'b0;
      frame_o <= '0;
    end else if (done_i) begin
      ready_o <= 1'b1;
      frame_o <= store_i;
    end else if (ack_i) begin
      ready_o <= 1'b0;
    end
  end

endmodule

// File: rtl/dcf_frame_assembler.sv
module dcf_frame_assembler
  import dcf_frame_pkg::*;
#(
  parameter int TICK_W     = 8,
  parameter int BUF_BYTES  = 8,
  parameter int FRAME_BITS = 59,
  parameter int ZERO_MIN   = 3,
  parameter int ZERO_MAX   = 5,
  parameter int ONE_MIN    = 7,
  parameter int ONE_MAX    = 9,
  parameter int MARK_LO    = 39,
  parameter int MARK_HI    = 84
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pulse_valid,
  input  logic [TICK_W-1:0]      pulse_ticks,
  input  logic                   host_ack,
  output logic                   frame_ready,
  output logic [BUF_BYTES*8-1:0] frame_data
);

  localparam int DATA_W = BUF_BYTES * 8;
  localparam int CNT_W  = $clog2(DATA_W);

  pulse_class_e      pulse_class;
  logic [CNT_W-1:0]  bit_cnt;
  logic              frame_done;
  logic [DATA_W-1:0] store_next;

  dcf_pulse_classify #(
    .TICK_W(TICK_W), .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX),
    .ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX), .MARK_LO(MARK_LO), .MARK_HI(MARK_HI)
  ) i_classify (
    .ticks_i (pulse_ticks),
    .class_o (pulse_class)
  );

  dcf_bit_store #(
    .BUF_BYTES(BUF_BYTES), .FRAME_BITS(FRAME_BITS)
  ) i_store (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (pulse_valid),
    .class_i  (pulse_class),
    .cnt_o    (bit_cnt),
    .done_o   (frame_done),
    .next_o   (store_next)
  );

  dcf_frame_hold #(
    .DATA_W(DATA_W)
  ) i_hold (
    .clk     (clk),
    .rst     (rst),
    .done_i  (frame_done),
    .ack_i   (host_ack),
    .store_i (store_next),
    .ready_o (frame_ready),
    .frame_o (frame_data)
  );

endmodule

// File: rtl/dcf_frame_assembler_chk.sv
module dcf_frame_assembler_chk #(
  parameter int TICK_W     = 8,
  parameter int DATA_W     = 64,
  parameter int CNT_W      = 6,
  parameter int FRAME_BITS = 59,
  parameter int ZERO_MIN   = 3,
  parameter int ZERO_MAX   = 5,
  parameter int ONE_MIN    = 7,
  parameter int ONE_MAX    = 9,
  parameter int MARK_LO    = 39,
  parameter int MARK_HI    = 84
) (
  input logic              clk,
  input logic              rst,
  input logic              pulse_valid,
  input logic [TICK_W-1:0] pulse_ticks,
  input logic              host_ack,
  input logic              frame_ready,
  input logic [DATA_W-1:0] frame_data,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              frame_done
);

  localparam logic [TICK_W-1:0] ZMIN = TICK_W'(ZERO_MIN);
  localparam logic [TICK_W-1:0] ZMAX = TICK_W'(ZERO_MAX);
  localparam logic [TICK_W-1:0] OMIN = TICK_W'(ONE_MIN);
  localparam logic [TICK_W-1:0] OMAX = TICK_W'(ONE_MAX);
  localparam logic [TICK_W-1:0] MLO  = TICK_W'(MARK_LO);
  localparam logic [TICK_W-1:0] MHI  = TICK_W'(MARK_HI);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0]  NBITS = CNT_W'(FRAME_BITS);

  AST_RUNT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    pulse_valid && pulse_ticks < ZMIN |=> bit_cnt == '0); // R1
  AST_ZERO_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    pulse_valid && pulse_ticks >= ZMIN && pulse_ticks <= ZMAX && bit_cnt != LAST
    |=> bit_cnt == CNT_W'($past(bit_cnt) + 1'b1)); // R2
  AST_ONE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    pulse_valid && pulse_ticks >= OMIN && pulse_ticks <= OMAX && bit_cnt != LAST
    |=> bit_cnt == CNT_W'($past(bit_cnt) + 1'b1)); // R3
  AST_MARK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    pulse_valid && pulse_ticks > MLO && pulse_ticks < MHI |=> bit_cnt == '0); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bit_cnt < NBITS); // R6
  AST_DONE_RAISES: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> frame_ready && bit_cnt == '0); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !pulse_valid |=> $stable(bit_cnt)); // R7
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    frame_ready && !host_ack |=> frame_ready); // R8
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    host_ack && !frame_done |=> !frame_ready); // R8
  AST_COLLIDE_WINS: assert property (@(posedge clk) disable iff (rst)
    frame_done && host_ack |=> frame_ready); // R9
  AST_FRAME_STABLE: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(frame_data)); // R11

endmodule

bind dcf_frame_assembler dcf_frame_assembler_chk #(
  .TICK_W(TICK_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FRAME_BITS(FRAME_BITS),
  .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX), .ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX),
  .MARK_LO(MARK_LO), .MARK_HI(MARK_HI)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .pulse_valid (pulse_valid),
  .pulse_ticks (pulse_ticks),
  .host_ack    (host_ack),
  .frame_ready (frame_ready),
  .frame_data  (frame_data),
  .bit_cnt     (bit_cnt),
  .frame_done  (frame_done)
);

// File: tb/test_dcf_frame_assembler.sv
module test_dcf_frame_assembler;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pulse_valid = 1'b0;
  logic [7:0]  pulse_ticks = '0;
  logic        host_ack = 1'b0;
  logic        frame_ready;
  logic [63:0] frame_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcf_frame_assembler i_dcf_frame_assembler (
    .clk(clk), .rst(rst), .pulse_valid(pulse_valid), .pulse_ticks(pulse_ticks),
    .host_ack(host_ack), .frame_ready(frame_ready), .frame_data(frame_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles exp below %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk_bit(input string req, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b exp %b", req, got, exp);
    end
  endtask

  task automatic chk_vec(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  // one strobe; returns at the following falling edge with outputs settled
  task automatic pulse(input int len, input logic ack = 1'b0);
    @(negedge clk);
    pulse_valid = 1'b1;
    pulse_ticks = 8'(len);
    host_ack    = ack;
    @(negedge clk);
    pulse_valid = 1'b0;
    host_ack    = 1'b0;
  endtask

  task automatic ack_host();
    @(negedge clk);
    host_ack = 1'b1;
    @(negedge clk);
    host_ack = 1'b0;
  endtask

  task automatic send_bits(input logic [63:0] pat, input int from, input int upto);
    for (int i = from; i <= upto; i++)
      pulse(pat[i] ? 7 + (i % 3) : 3 + (i % 3));
  endtask

  function automatic logic [63:0] expect_frame(input logic [63:0] pat);
    return {5'b0, pat[58:0]};
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_bit("R10 ready after reset", frame_ready, 1'b0);
    chk_vec("R10 frame after reset", frame_data, '0);
  endtask

  task automatic t_basic_frame();
    logic [63:0] pat = 64'h0123_4567_89AB_CDEF;
    pulse(60);
    send_bits(pat, 0, 57);
    chk_bit("R6 not ready before bit 58", frame_ready, 1'b0);
    chk_vec("R11 frame unchanged mid-minute", frame_data, '0);
    send_bits(pat, 58, 58);
    chk_bit("R6 ready after bit 58", frame_ready, 1'b1);
    chk_vec("R2 R3 R5 frame content", frame_data, expect_frame(pat));
  endtask

  task automatic t_hold_and_ack();
    logic [63:0] keep = frame_data;
    repeat (8) @(negedge clk);
    chk_bit("R8 ready held without ack", frame_ready, 1'b1);
    send_bits(64'hFFFF_FFFF_FFFF_FFFF, 0, 19);
    chk_vec("R11 frame stable under new bits", frame_data, keep);
    chk_bit("R8 still ready", frame_ready, 1'b1);
    ack_host();
    chk_bit("R8 ack clears ready", frame_ready, 1'b0);
    chk_vec("R11 frame kept after ack", frame_data, keep);
  endtask

  task automatic t_minute_mark();
    logic [63:0] pat = 64'hF0F0_1234_5555_AAAA;
    send_bits(64'hFFFF_FFFF_FFFF_FFFF, 0, 9);
    pulse(40);
    send_bits(pat, 0, 57);
    chk_bit("R4 mark 40 restarts count", frame_ready, 1'b0);
    send_bits(pat, 58, 58);
    chk_bit("R4 ready after mark 40", frame_ready, 1'b1);
    chk_vec("R4 frame after mark 40", frame_data, expect_frame(pat));
    ack_host();
    send_bits(pat, 0, 30);
    pulse(83);
    send_bits(~pat, 0, 57);
    chk_bit("R4 mark 83 restarts count", frame_ready, 1'b0);
    send_bits(~pat, 58, 58);
    chk_vec("R4 frame after mark 83", frame_data, expect_frame(~pat));
    ack_host();
  endtask

  task automatic t_runt();
    logic [63:0] pat = 64'h7FFF_0000_FFFF_0001;
    send_bits(64'hFFFF_FFFF_FFFF_FFFF, 0, 24);
    pulse(2);
    send_bits(pat, 0, 57);
    chk_bit("R1 runt 2 restarts count", frame_ready, 1'b0);
    send_bits(pat, 58, 58);
    chk_vec("R1 frame after runt 2", frame_data, expect_frame(pat));
    ack_host();
    send_bits(pat, 0, 40);
    pulse(0);
    send_bits(~pat, 0, 58);
    chk_vec("R1 frame after runt 0", frame_data, expect_frame(~pat));
    ack_host();
  endtask

  task automatic t_ignored();
    logic [63:0] pat = 64'h0A5A_C3C3_9696_E11E;
    pulse(50);
    send_bits(pat, 0, 29);
    pulse(6); pulse(10); pulse(39); pulse(84); pulse(255);
    repeat (4) @(negedge clk);
    send_bits(pat, 30, 57);
    chk_bit("R7 ignored lengths do not advance", frame_ready, 1'b0);
    send_bits(pat, 58, 58);
    chk_bit("R7 ready on expected pulse", frame_ready, 1'b1);
    chk_vec("R7 store untouched by ignored", frame_data, expect_frame(pat));
    ack_host();
  endtask

  task automatic t_collide();
    logic [63:0] p1 = 64'h1111_2222_3333_4444;
    logic [63:0] p2 = 64'hCAFE_F00D_DEAD_BEEF;
    pulse(60);
    send_bits(p1, 0, 58);
    chk_bit("R9 first frame ready", frame_ready, 1'b1);
    send_bits(p2, 0, 57);
    pulse(p2[58] ? 8 : 4, 1'b1);
    chk_bit("R9 completion beats ack", frame_ready, 1'b1);
    chk_vec("R9 new frame shown", frame_data, expect_frame(p2));
    ack_host();
    chk_bit("R8 later ack clears", frame_ready, 1'b0);
  endtask

  task automatic t_reset_mid();
    logic [63:0] pat = 64'h5A5A_5A5A_A5A5_A5A5;
    send_bits(64'hFFFF_FFFF_FFFF_FFFF, 0, 58);
    send_bits(64'hFFFF_FFFF_FFFF_FFFF, 0, 9);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_bit("R10 reset drops ready", frame_ready, 1'b0);
    chk_vec("R10 reset clears frame", frame_data, '0);
    send_bits(pat, 0, 57);
    chk_bit("R10 reset clears count", frame_ready, 1'b0);
    send_bits(pat, 58, 58);
    chk_vec("R10 unwritten top bits zero", frame_data, expect_frame(pat));
  endtask

  initial begin
    t_reset();
    t_basic_frame();
    t_hold_and_ack();
    t_minute_mark();
    t_runt();
    t_ignored();
    t_collide();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule